// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the completion interrupt levels of fifteen DMA channels into one place for software to read. It keeps a global status word with one bit per channel. It folds the channels onto twelve interrupt lines: channels 0 to 10 each get a line of their own, and channels 11 to 14 share the last line. A second-level controller sits above the lines. It shows the raw line levels in a pending word, masks them with a set/clear enable word, and reduces the enabled result to a single summary bit in a basic-pending word. Any nonzero basic-pending word raises the CPU interrupt request.

Software reaches every register through one simple register port. A request is presented for one cycle. Read data and a valid strobe come back on the following cycle. The channel levels are sampled into the status register once, and all later stages derive from that sampled copy. Software therefore always sees status, lines and pending bits that agree with each other.

Register addresses on the port are: channel status 0x0FE0, basic pending 0x1200, line pending 0x1204, enable-set 0x1210, enable-clear 0x121C.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset, the status, line-pending, basic-pending and enable words all read 0, every interrupt line is low and cpu_irq is low.
- R2: Bit n of the status word (0x0FE0) equals the level of chan_irq[n] sampled at the previous clock edge.
- R3: For k from 0 to 10, irq_line[k] follows the sampled level of channel k, one cycle after chan_irq changes.
- R4: irq_line[11] is the OR of the sampled levels of channels 11 to 14.
- R5: Bit 16+k of the line-pending word (0x1204) equals irq_line[k], whatever the enable bits hold. Every other bit of that word reads 0.
- R6: A write to the enable-set word (0x1210) sets each enable bit whose write-data bit is 1 and leaves the rest unchanged. Writing 0 changes nothing. The word reads back the current enables.
- R7: A write to the enable-clear word (0x121C) clears each enable bit whose write-data bit is 1. This word always reads 0.
- R8: Bit 8 of the basic-pending word (0x1200) is 1 exactly when some line-pending bit and its enable bit are both 1. All other bits of the word read 0.
- R9: cpu_irq is 1 in the cycle after the basic-pending word is nonzero, and 0 in the cycle after it is zero.
- R10: Read data and reg_rvalid appear one cycle after a read request. Unmapped addresses read 0. Writes to read-only words change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_irq | input | 15 | Per-channel completion interrupt levels |
| reg_valid | input | 1 | Register request strobe |
| reg_write | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_line | output | 12 | Interrupt line vector |
| cpu_irq | output | 1 | CPU interrupt request |

## Verification
The assertions check four things on every cycle: the status register tracks the channel levels with one cycle of delay, the dedicated and shared lines follow the sampled channel levels, enable bits fall only on a clear write, and cpu_irq and the read strobe each lag their cause by one cycle. The bench scenarios are needed to show the rest. They show the exact bit placement of lines inside the pending word and that pending ignores the enables. They show that writing 0 to the enable-set word leaves the enables alone and that the summary bit reacts to masking. They also show that unmapped or read-only addresses neither return data nor change state.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int DW = 32;
    localparam int AW = 16;

    localparam logic [AW-1:0] ADDR_STATUS = 16'h0FE0;
    localparam logic [AW-1:0] ADDR_BASIC  = 16'h1200;
    localparam logic [AW-1:0] ADDR_PEND1  = 16'h1204;
    localparam logic [AW-1:0] ADDR_ENSET  = 16'h1210;
    localparam logic [AW-1:0] ADDR_ENCLR  = 16'h121C;

    typedef struct packed {
        logic          set_we;
        logic          clr_we;
        logic [DW-1:0] wdata;
    } en_wr_t;
endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
    parameter int NUM_CHAN      = 15,
    parameter int NUM_DEDICATED = 11,
    localparam int NUM_LINES    = NUM_DEDICATED + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CHAN-1:0]  chan_irq,
    output logic [NUM_CHAN-1:0]  status_o,
    output logic [NUM_LINES-1:0] line_o
);
    typedef struct packed {
        logic [NUM_CHAN-1:0] status;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = chan_irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // Channels below NUM_DEDICATED own a line; the remainder share the last one.
    for (genvar k = 0; k < NUM_DEDICATED; k++) begin : g_dedicated
        assign line_o[k] = st_q.status[k];
    end
    assign line_o[NUM_LINES-1] = |st_q.status[NUM_CHAN-1:NUM_DEDICATED];

    // R2: status mirrors the channel levels one edge later
    a_r2_status_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> status_o == $past(chan_irq));

    // R3: dedicated lines follow their channel after one register
    a_r3_dedicated_line: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> line_o[NUM_DEDICATED-1:0] == $past(chan_irq[NUM_DEDICATED-1:0]));

    // R4: shared line is the OR of the upper channels, one edge later
    a_r4_shared_line: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> line_o[NUM_LINES-1] == (|$past(chan_irq[NUM_CHAN-1:NUM_DEDICATED])));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NUM_LINES = 12,
    parameter int LINE_BIT0 = 16,
    parameter int AGG_BIT   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  en_wr_t               wr_i,
    output logic [DW-1:0]        pend1_o,
    output logic [DW-1:0]        en1_o,
    output logic [DW-1:0]        basic_o,
    output logic                 cpu_irq_o
);
    typedef struct packed {
        logic [DW-1:0] en1;
        logic          cpu_irq;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] pend1;
    logic [DW-1:0] basic;

    always_comb begin
        pend1                          = '0;
        pend1[LINE_BIT0 +: NUM_LINES]  = line_i;
        basic                          = '0;
        basic[AGG_BIT]                 = |(pend1 & st_q.en1);

        st_d = st_q;
        if (wr_i.set_we) st_d.en1 = st_q.en1 | wr_i.wdata;
        if (wr_i.clr_we) st_d.en1 = st_q.en1 & ~wr_i.wdata;
        st_d.cpu_irq = |basic;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend1_o   = pend1;
    assign en1_o     = st_q.en1;
    assign basic_o   = basic;
    assign cpu_irq_o = st_q.cpu_irq;

    // R7: enable bits only fall through a clear write
    a_r7_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_i.clr_we)) |-> ((en1_o & $past(en1_o)) == $past(en1_o)));

    // R6: enable bits only rise through a set write
    a_r6_enable_set_only: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_i.set_we)) |-> ((en1_o & ~$past(en1_o)) == '0));

    // R9: the request lags the summary by one cycle
    a_r9_cpu_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cpu_irq_o == ($past(basic_o) != '0));
endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
    import dma_irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_valid,
    input  logic          reg_write,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] status_i,
    input  logic [DW-1:0] pend1_i,
    input  logic [DW-1:0] en1_i,
    input  logic [DW-1:0] basic_i,
    output en_wr_t        wr_o,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          rvalid;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] rmux;

    always_comb begin
        unique case (reg_addr)
            ADDR_STATUS: rmux = status_i;
            ADDR_BASIC:  rmux = basic_i;
            ADDR_PEND1:  rmux = pend1_i;
            ADDR_ENSET:  rmux = en1_i;
            default:     rmux = '0;
        endcase

        wr_o.set_we = reg_valid && reg_write && (reg_addr == ADDR_ENSET);
        wr_o.clr_we = reg_valid && reg_write && (reg_addr == ADDR_ENCLR);
        wr_o.wdata  = reg_wdata;

        st_d        = st_q;
        st_d.rvalid = reg_valid && !reg_write;
        if (reg_valid && !reg_write) st_d.rdata = rmux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;

    // R10: read strobe returns one cycle after a read request
    a_r10_rvalid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rvalid_o == $past(reg_valid && !reg_write));

    // R10: a set and a clear never happen together
    a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_o.set_we && wr_o.clr_we));
endmodule

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int NUM_CHAN      = 15,
    parameter int NUM_DEDICATED = 11,
    parameter int LINE_BIT0     = 16,
    parameter int AGG_BIT       = 8,
    localparam int NUM_LINES    = NUM_DEDICATED + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CHAN-1:0]  chan_irq,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 reg_rvalid,
    output logic [NUM_LINES-1:0] irq_line,
    output logic                 cpu_irq
);
    logic [NUM_CHAN-1:0] status;
    logic [DW-1:0]       status_w;
    logic [DW-1:0]       pend1;
    logic [DW-1:0]       en1;
    logic [DW-1:0]       basic;
    en_wr_t              en_wr;

    always_comb begin
        status_w                = '0;
        status_w[NUM_CHAN-1:0]  = status;
    end

    dma_irq_status #(
        .NUM_CHAN      (NUM_CHAN),
        .NUM_DEDICATED (NUM_DEDICATED)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_irq (chan_irq),
        .status_o (status),
        .line_o   (irq_line)
    );

    dma_irq_ctrl #(
        .NUM_LINES (NUM_LINES),
        .LINE_BIT0 (LINE_BIT0),
        .AGG_BIT   (AGG_BIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (irq_line),
        .wr_i      (en_wr),
        .pend1_o   (pend1),
        .en1_o     (en1),
        .basic_o   (basic),
        .cpu_irq_o (cpu_irq)
    );

    dma_irq_regif u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_i  (status_w),
        .pend1_i   (pend1),
        .en1_i     (en1),
        .basic_i   (basic),
        .wr_o      (en_wr),
        .rdata_o   (reg_rdata),
        .rvalid_o  (reg_rvalid)
    );

    // R1: no line and no request while nothing has been sampled since reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (irq_line == '0 && !cpu_irq));
endmodule

// File: tb/dma_irq_aggregator_tb_top.sv
module dma_irq_aggregator_tb_top;
    localparam logic [15:0] A_STAT  = 16'h0FE0;
    localparam logic [15:0] A_BASIC = 16'h1200;
    localparam logic [15:0] A_PEND  = 16'h1204;
    localparam logic [15:0] A_ENS   = 16'h1210;
    localparam logic [15:0] A_ENC   = 16'h121C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] chan_irq = '0;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [11:0] irq_line;
    logic        cpu_irq;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dma_irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .irq_line(irq_line), .cpu_irq(cpu_irq)
    );

    function automatic logic [11:0] exp_lines(input logic [14:0] c);
        logic [11:0] l;
        l[10:0] = c[10:0];
        l[11]   = |c[14:11];
        return l;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        chk("R10 rvalid", {31'd0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic set_chan(input logic [14:0] c);
        @(negedge clk);
        chan_irq = c;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 lines", {20'd0, irq_line}, 32'd0);
        chk("R1 cpu_irq", {31'd0, cpu_irq}, 32'd0);
        rd(A_STAT, d);  chk("R1 status", d, 32'd0);
        rd(A_PEND, d);  chk("R1 pend", d, 32'd0);
        rd(A_BASIC, d); chk("R1 basic", d, 32'd0);
        rd(A_ENS, d);   chk("R1 enable", d, 32'd0);
    endtask

    task automatic t_walk();
        logic [31:0] d;
        for (int n = 0; n < 15; n++) begin
            logic [14:0] c;
            c = 15'd1 << n;
            set_chan(c);
            chk("R3 R4 lines", {20'd0, irq_line}, {20'd0, exp_lines(c)});
            rd(A_STAT, d); chk("R2 status", d, {17'd0, c});
            rd(A_PEND, d); chk("R5 pend raw", d, {4'd0, exp_lines(c), 16'd0});
        end
        set_chan(15'h7800);
        chk("R4 shared all", {20'd0, irq_line}, 32'h800);
        set_chan(15'h0A05);
        chk("R3 mix", {20'd0, irq_line}, {20'd0, exp_lines(15'h0A05)});
        set_chan('0);
        chk("R3 clear", {20'd0, irq_line}, 32'd0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(A_ENS, 32'h0800_0000);
        rd(A_ENS, d); chk("R6 set", d, 32'h0800_0000);
        wr(A_ENS, 32'h0000_0000);
        rd(A_ENS, d); chk("R6 write zero ignored", d, 32'h0800_0000);
        wr(A_ENS, 32'h0001_0000);
        rd(A_ENS, d); chk("R6 set accumulates", d, 32'h0801_0000);
        wr(A_ENC, 32'h0800_0000);
        rd(A_ENS, d); chk("R7 clear", d, 32'h0001_0000);
        rd(A_ENC, d); chk("R7 reads zero", d, 32'd0);
    endtask

    task automatic t_summary();
        logic [31:0] d;
        set_chan(15'h4000);
        rd(A_BASIC, d); chk("R8 masked", d, 32'd0);
        chk("R9 masked", {31'd0, cpu_irq}, 32'd0);
        rd(A_PEND, d); chk("R5 pend ignores enable", d, 32'h0800_0000);
        wr(A_ENS, 32'h0800_0000);
        rd(A_BASIC, d); chk("R8 agg bit", d, 32'h0000_0100);
        chk("R9 cpu_irq", {31'd0, cpu_irq}, 32'd1);
        set_chan('0);
        @(negedge clk);
        chk("R9 cpu_irq drops", {31'd0, cpu_irq}, 32'd0);
        set_chan(15'h0001);
        rd(A_BASIC, d); chk("R8 line0 enabled", d, 32'h0000_0100);
        wr(A_ENC, 32'hFFFF_FFFF);
        rd(A_BASIC, d); chk("R8 after clear", d, 32'd0);
        chk("R9 after clear", {31'd0, cpu_irq}, 32'd0);
        set_chan('0);
    endtask

    task automatic t_port();
        logic [31:0] d;
        rd(16'h0000, d); chk("R10 unmapped", d, 32'd0);
        wr(A_STAT, 32'hFFFF_FFFF);
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_BASIC, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R10 status ro", d, 32'd0);
        rd(A_BASIC, d); chk("R10 basic ro", d, 32'd0);
        rd(A_ENS, d); chk("R10 enable untouched", d, 32'd0);
        @(negedge clk);
        chk("R10 no rvalid idle", {31'd0, reg_rvalid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_walk();
        t_enable();
        t_summary();
        t_port();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule